// File: doc/BRIEF.md
# Pulse-Width and Rate-Multiplied Tuning DAC

This block converts a 14-bit tuning word into one digital output whose time-averaged level is proportional to the word. A low-pass RC network and an amplifier outside the chip turn that stream into the analog tuning voltage. The word is split in two. The upper seven bits give a pulse width, in counts, inside each 128-count coarse cycle. The lower seven bits add one extra count of width to an evenly spread subset of the 128 coarse cycles that make up a full 16384-count period. This is bit-rate multiplication, so small words give many narrow pulses rather than one wide one.

Software loads the word through a byte-wide write port into two holding registers. A divide-by-four clock enable derived from the system clock steps a 14-bit reference counter. The holding registers are copied into the active compare register only when the counter wraps, so writing the two bytes at different times never produces a mixed word on the output. The write port follows valid/ready rules: a byte is taken on every rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is held high at all times, so the port never applies back-pressure and a writer may keep `wr_valid` asserted on consecutive cycles.

Top module: `tune_dac`

## Requirements
- R1: A write with `wr_addr`=0 loads word bits 7..0 from `wr_data[7:0]`. A write with `wr_addr`=1 loads word bits 13..8 from `wr_data[5:0]`, and `wr_data[7:6]` have no effect. `wr_ready` is always 1.
- R2: The reference counter advances once every 4 system clocks. `dac_out` changes only on edges whose number is a multiple of 4, counting the first rising edge after reset release as edge 1.
- R3: Over any full period of 16384 counts under one active word, `dac_out` is high for exactly as many counts as the word's value.
- R4: Counter count n has coarse cycle c = n[13:7] and position p = n[6:0]. The output is high at p when p < coarse + e. Here e = 1 when c is nonzero and fine bit (6 - t) is set, t being the number of trailing zeros of c; otherwise e = 0. For a word of 1, the only high count is count 8192 of the period.
- R5: A word below 128 gives exactly that many separate one-count high pulses per period.
- R6: A word of zero keeps `dac_out` low for the whole period.
- R7: The all-ones word 16383 gives exactly one low count per period, at count 127 (coarse cycle 0, position 127).
- R8: A word written during a period takes effect only from the next period boundary. The period in progress completes with the previous word.
- R9: During reset and until the first period boundary after reset, `dac_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Write acceptance, constantly high |
| wr_addr | input | 1 | Register select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Write data byte |
| dac_out | output | 1 | Modulated push-pull output |

## Verification
The bench checks the fine-pulse placement at its extremes. A word of 1 must put its single count in the middle of the period. A design with the bit order reversed would place it in an odd cycle, and one that lets cycle 0 receive a fine pulse would miscount the all-ones word. The all-ones and zero words check the carry when coarse plus the extra count reaches 128: a truncated sum leaves a long low gap instead of one low count. The bench also writes the next word partway through each measured period. A design that loads immediately would corrupt the high count. It writes junk into the two unused high bits, so a design that kept them would shift the word. A second instance at the default divider is watched for output edges off the four-clock grid and for a wrong high count over its first loaded period.

// File: rtl/tdac_pkg.sv
package tdac_pkg;

  typedef enum logic {
    REG_LOW  = 1'b0,
    REG_HIGH = 1'b1
  } tdac_reg_e;

  localparam int MAXW = 16;

  // Extra-count select: lowest set bit k of the cycle index picks fine bit (nbits-1-k).
  function automatic logic fine_hit(input logic [MAXW-1:0] cyc,
                                    input logic [MAXW-1:0] fine,
                                    input int nbits);
    logic hit;
    logic found;
    int   idx;
    hit   = 1'b0;
    found = 1'b0;
    for (int k = 0; k < MAXW; k++) begin
      if (k < nbits && !found && cyc[k]) begin
        found = 1'b1;
        idx   = nbits - 1 - k;
        hit   = fine[idx[3:0]];
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/tdac_hold.sv
module tdac_hold
  import tdac_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [7:0]   wr_data,
  output logic [W-1:0] hold_word
);
  localparam int HI_W = W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;

  // Holding bytes carry no reset: their content is undefined until written.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (tdac_reg_e'(wr_addr) == REG_HIGH) hi_q <= wr_data[HI_W-1:0];
      else                                  lo_q <= wr_data;
    end
  end

  assign hold_word = {hi_q, lo_q};
endmodule

// File: rtl/tdac_timebase.sv
module tdac_timebase #(
  parameter int DIV = 4,
  parameter int W   = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         tick,
  output logic [W-1:0] cnt,
  output logic         period_end
);
  logic [W-1:0] cnt_q;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + PW'(1);
      end

      assign tick = (pre_q == LAST);

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + W'(1);
  end

  assign cnt        = cnt_q;
  assign period_end = tick && (cnt_q == '1);
endmodule

// File: rtl/tdac_mod.sv
module tdac_mod
  import tdac_pkg::*;
#(
  parameter int CW = 7,
  parameter int FW = 7,
  localparam int W = CW + FW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         period_end,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] hold_word,
  output logic         dac_out
);
  localparam logic [W-1:0] GAP_CNT = W'((1 << CW) - 1);

  logic [W-1:0]  act_q;
  logic          vld_q;
  logic          out_q;
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  logic [FW-1:0] cyc;
  logic [CW-1:0] pos;
  logic          ext;
  logic [CW:0]   limit;
  logic          high_now;

  assign coarse = act_q[W-1:FW];
  assign fine   = act_q[FW-1:0];
  assign cyc    = cnt[W-1:CW];
  assign pos    = cnt[CW-1:0];

  assign ext      = fine_hit(MAXW'(cyc), MAXW'(fine), FW);
  assign limit    = {1'b0, coarse} + (CW+1)'(ext);
  assign high_now = vld_q && ({1'b0, pos} < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      vld_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (period_end) begin
        act_q <= hold_word;
        vld_q <= 1'b1;
      end
      if (tick) out_q <= high_now;
    end
  end

  assign dac_out = out_q;

  // R8
  load_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(period_end));

  // R2
  out_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(tick));

  // R9
  quiet_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |=> !out_q);

  // R6
  zero_word_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && act_q == '0 && tick) |=> !out_q);

  // R7
  full_word_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && act_q == '1 && tick && cnt != GAP_CNT) |=> out_q);
endmodule

// File: rtl/tune_dac.sv
module tune_dac #(
  parameter int DIV = 4,
  parameter int CW  = 7,
  parameter int FW  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       dac_out
);
  localparam int W = CW + FW;

  logic [W-1:0] hold_word;
  logic [W-1:0] cnt;
  logic         tick;
  logic         period_end;
  logic         wr_en;

  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid && wr_ready;

  tdac_hold #(.W(W)) u_hold (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hold_word (hold_word)
  );

  tdac_timebase #(.DIV(DIV), .W(W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cnt        (cnt),
    .period_end (period_end)
  );

  tdac_mod #(.CW(CW), .FW(FW)) u_mod (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .period_end (period_end),
    .cnt        (cnt),
    .hold_word  (hold_word),
    .dac_out    (dac_out)
  );
endmodule

// File: tb/tune_dac_test.sv
`timescale 1ns/1ps
module tune_dac_test;
  localparam int PER = 16384;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, dac_out;
  logic       wr_ready_d4, d4_out;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  int d4_early = 0, d4_misal = 0, d4_edges = 0, d4_high = 0;
  logic d4_prev = 1'b0;

  always #2.5 clk = ~clk;

  // Main instance runs the counter every clock to keep periods short.
  tune_dac #(.DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .dac_out(dac_out)
  );

  // Default divider instance, same write traffic.
  tune_dac uut_d4 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready_d4),
    .wr_addr(wr_addr), .wr_data(wr_data), .dac_out(d4_out)
  );

  always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (edge_n <= 4 * PER && d4_out) d4_early++;
      if (d4_out != d4_prev) begin
        d4_edges++;
        if (edge_n % 4 != 0) d4_misal++;
      end
      if (edge_n >= 4 * PER + 4 && edge_n <= 8 * PER + 3 && d4_out) d4_high++;
      d4_prev = d4_out;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures one full period under word w while writing nxt into the holding registers.
  task automatic measure(input logic [13:0] w, input logic [13:0] nxt,
                         input logic [1:0] junk, input string tag);
    int   highs = 0, rises = 0, first = -1, nlow = 0, low_at = -1;
    logic prev = 1'b0;
    for (int j = 0; j < PER; j++) begin
      @(negedge clk);
      if (dac_out) begin
        highs++;
        if (!prev) rises++;
        if (first < 0) first = j;
      end else begin
        nlow++;
        low_at = j;
      end
      prev = dac_out;
      if (j == 0) begin
        wr_valid = 1'b1; wr_addr = 1'b0; wr_data = nxt[7:0];
      end else if (j == 1) begin
        wr_addr = 1'b1; wr_data = {junk, nxt[13:8]};
      end else if (j == 2) begin
        wr_valid = 1'b0;
      end
    end
    // R3 and R8: count matches the word loaded at the boundary despite mid-period writes
    chk(highs == int'(w), tag, highs, int'(w));
    if (w < 14'd128) chk(rises == int'(w), "R5 pulse count", rises, int'(w));
    if (w == 14'd0)  chk(highs == 0, "R6 zero word", highs, 0);
    if (w == 14'd1)  chk(first == 8192, "R4 fine pulse position", first, 8192);
    if (w == 14'h3FFF) begin
      chk(nlow == 1, "R7 low count", nlow, 1);
      chk(low_at == 127, "R7 low position", low_at, 127);
    end
  endtask

  task automatic test_reset_and_preload();
    int bad = 0;
    repeat (3) @(negedge clk);
    chk(dac_out == 1'b0, "R9 reset output", int'(dac_out), 0);
    chk(wr_ready == 1'b1, "R1 ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    wr_valid = 1'b1; wr_addr = 1'b0; wr_data = 8'h01;
    @(negedge clk);
    if (dac_out) bad++;
    wr_addr = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    if (dac_out) bad++;
    wr_valid = 1'b0;
    while (edge_n < PER) begin
      @(negedge clk);
      if (dac_out) bad++;
    end
    chk(bad == 0, "R9 low before first boundary", bad, 0);
  endtask

  task automatic test_divider();
    chk(d4_early == 0, "R9 divided instance low before boundary", d4_early, 0);
    chk(d4_misal == 0, "R2 edges on 4-clock grid", d4_misal, 0);
    chk(d4_edges > 0, "R2 divided instance toggles", d4_edges, 1);
    chk(d4_high == 16383 * 4, "R2 divided high clocks", d4_high, 16383 * 4);
  endtask

  initial begin
    logic [13:0] r1, r2, r3;
    r1 = 14'($urandom_range(0, 16383));
    r2 = 14'($urandom_range(0, 16383));
    r3 = 14'($urandom_range(0, 16383));
    test_reset_and_preload();
    measure(14'd1,     14'd127,   2'b00, "R3 word 1");
    measure(14'd127,   14'd128,   2'b11, "R3 word 127");
    measure(14'd128,   14'h3FFF,  2'b00, "R1 R3 word 128 with junk high bits");
    measure(14'h3FFF,  14'd0,     2'b00, "R3 word 16383");
    measure(14'd0,     r1,        2'b10, "R3 word 0");
    measure(r1,        r2,        2'b01, "R3 R8 random word a");
    measure(r2,        r3,        2'b00, "R3 R8 random word b");
    measure(r3,        14'd5,     2'b00, "R3 R8 random word c");
    test_divider();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog expired actual %0d expected %0d", edge_n, 9 * PER);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule